// File: doc/BRIEF.md
# Operand Select and Execute Unit

This block is the execute stage of a load/store processor core. In one cycle it takes a 32-bit instruction word and the values of two source registers. It then yields one of two things: an ALU result, or an effective address with the size and extension attributes of a load or store. The second operand is either the second register value or a 13-bit immediate, sign-extended to 32 bits. One selector bit in the instruction makes that choice. The selected operand feeds both the ALU and the address adder.

A four-bit condition register holds negative, zero, overflow and carry. It is written only by ALU instructions that have their set-condition bit raised, and only while the issue strobe is high. Carry variants of add and subtract read the stored carry. Instruction fetch, the register file, memory access and branch resolution sit outside the block.

Instruction layout (bit positions): opcode [31:25], set-condition [24], destination index [23:19], first source index [18:14], operand selector [13], immediate or second source field [12:0].

Top module: `ex_unit`

## Requirements
- R1: With selector bit 13 at 0, the second operand is `src_b`. With it at 1, the second operand is bits [12:0] sign-extended to 32 bits, and `src_b` has no effect.
- R2: Opcode 0x01 gives a + op2. Opcode 0x02 gives a + op2 + C, where C is the stored carry flag.
- R3: Opcode 0x03 gives a − op2 and 0x04 gives a − op2 − (1 − C). Opcode 0x05 gives op2 − a and 0x06 gives op2 − a − (1 − C). For all four, C is set to 1 when no borrow occurs.
- R4: Opcodes 0x07, 0x08 and 0x09 give a AND op2, a OR op2 and a XOR op2.
- R5: Opcodes 0x0A, 0x0B and 0x0C shift a left logically, right logically and right arithmetically. The shift amount is op2[4:0], and the upper bits of op2 are ignored.
- R6: `flags` = {N,Z,V,C}. N is result bit 31. Z is set when the result is zero. V is two's-complement overflow for add and subtract. For logic and shift opcodes, C and V are 0.
- R7: `flags` changes only after a clock edge where `issue` is 1, the set-condition bit 24 is 1 and the opcode is an ALU opcode (0x01–0x0C). Otherwise it holds its value.
- R8: Memory opcodes 0x10–0x17 (indexed) give `eff_addr` = `src_a` + op2.
- R9: Memory opcodes 0x18–0x1F (PC-relative) give `eff_addr` = `pc` + op2.
- R10: For memory opcodes, bits [2:0] select the access: 0 loads a word, 1 loads a signed half, 2 loads an unsigned half, 3 loads a signed byte, 4 loads an unsigned byte, 5 stores a word, 6 stores a half, 7 stores a byte. `mem_size` is 2 for word, 1 for half and 0 for byte. `mem_sext` is 1 only for signed loads. Loads raise `mem_rd` and stores raise `mem_wr`, each only while `issue` is 1.
- R11: After reset, `flags` is 0, and with `issue` low no strobe is raised.
- R12: Any other opcode raises neither `alu_we`, `mem_rd` nor `mem_wr`, and leaves `flags` unchanged.
- R13: `dst_idx` and `src_a_idx` present instruction bits [23:19] and [18:14].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction valid this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| alu_res | output | 32 | ALU result |
| alu_we | output | 1 | ALU result valid |
| eff_addr | output | 32 | Effective address |
| mem_rd | output | 1 | Load request |
| mem_wr | output | 1 | Store request |
| mem_size | output | 2 | Access size: 0 byte, 1 half, 2 word |
| mem_sext | output | 1 | Sign-extend loaded data |
| flags | output | 4 | Condition register {N,Z,V,C} |
| dst_idx | output | 5 | Destination register index |
| src_a_idx | output | 5 | First source register index |

## Verification
Some properties are checked by assertions on every cycle:
- flags hold whenever no flag-setting ALU instruction issues;
- N and Z, when written, agree with the previous cycle's result;
- the three strobes are never raised together;
- an immediate operand is always a proper sign extension;
- logic and shift opcodes never produce carry or overflow.

Other behaviours can only be shown by the bench's sweeps:
- the arithmetic values of every opcode;
- borrow semantics in the carry variants;
- the choice between indexed and PC-relative base;
- the size and extension encodings;
- the rejection of undefined opcodes.

// File: rtl/ex_pkg.sv
package ex_pkg;

  localparam int OP_BITS = 7;

  typedef enum logic [2:0] {
    AK_ARITH = 3'd0,
    AK_AND   = 3'd1,
    AK_OR    = 3'd2,
    AK_XOR   = 3'd3,
    AK_SLL   = 3'd4,
    AK_SRL   = 3'd5,
    AK_SRA   = 3'd6
  } alu_kind_e;

  typedef struct packed {
    logic      is_alu;
    logic      is_mem;
    logic      is_store;
    logic      rel;
    logic [1:0] size;
    logic      sext;
    alu_kind_e kind;
    logic      sub;
    logic      rev;
    logic      use_c;
  } dec_t;

endpackage

// File: rtl/ex_decode.sv
module ex_decode
  import ex_pkg::*;
(
  input  logic [OP_BITS-1:0] op,
  output dec_t               d
);

  always_comb begin
    d      = '0;
    d.kind = AK_ARITH;
    if (op[OP_BITS-1:4] == '0 && op[3:0] == 4'h0) begin
      d = d;
    end else if (op[OP_BITS-1:4] == 3'b001) begin
      d.is_mem = 1'b1;
      d.rel    = op[3];
      case (op[2:0])
        3'd0:    d.size = 2'd2;
        3'd1:    begin d.size = 2'd1; d.sext = 1'b1; end
        3'd2:    d.size = 2'd1;
        3'd3:    begin d.size = 2'd0; d.sext = 1'b1; end
        3'd4:    d.size = 2'd0;
        3'd5:    begin d.size = 2'd2; d.is_store = 1'b1; end
        3'd6:    begin d.size = 2'd1; d.is_store = 1'b1; end
        default: begin d.size = 2'd0; d.is_store = 1'b1; end
      endcase
    end else begin
      case (op)
        7'h01: d.is_alu = 1'b1;
        7'h02: begin d.is_alu = 1'b1; d.use_c = 1'b1; end
        7'h03: begin d.is_alu = 1'b1; d.sub = 1'b1; end
        7'h04: begin d.is_alu = 1'b1; d.sub = 1'b1; d.use_c = 1'b1; end
        7'h05: begin d.is_alu = 1'b1; d.sub = 1'b1; d.rev = 1'b1; end
        7'h06: begin d.is_alu = 1'b1; d.sub = 1'b1; d.rev = 1'b1; d.use_c = 1'b1; end
        7'h07: begin d.is_alu = 1'b1; d.kind = AK_AND; end
        7'h08: begin d.is_alu = 1'b1; d.kind = AK_OR;  end
        7'h09: begin d.is_alu = 1'b1; d.kind = AK_XOR; end
        7'h0A: begin d.is_alu = 1'b1; d.kind = AK_SLL; end
        7'h0B: begin d.is_alu = 1'b1; d.kind = AK_SRL; end
        7'h0C: begin d.is_alu = 1'b1; d.kind = AK_SRA; end
        default: d = d;
      endcase
    end
  end

endmodule

// File: rtl/ex_alu.sv
module ex_alu
  import ex_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_kind_e    kind,
  input  logic         sub,
  input  logic         rev,
  input  logic         use_c,
  input  logic         c_in,
  output logic [W-1:0] y,
  output logic [3:0]   nzvc
);

  localparam int SHW = $clog2(W);

  logic [W-1:0]   x_op, y_pre, y_op;
  logic           ci;
  logic [W:0]     sum;
  logic [SHW-1:0] sh;
  logic           c_o, v_o;

  always_comb begin
    x_op  = rev ? b : a;
    y_pre = rev ? a : b;
    y_op  = sub ? ~y_pre : y_pre;
    ci    = use_c ? c_in : sub;
    sum   = {1'b0, x_op} + {1'b0, y_op} + {{W{1'b0}}, ci};
    sh    = b[SHW-1:0];
    c_o   = 1'b0;
    v_o   = 1'b0;
    case (kind)
      AK_AND:  y = a & b;
      AK_OR:   y = a | b;
      AK_XOR:  y = a ^ b;
      AK_SLL:  y = a << sh;
      AK_SRL:  y = a >> sh;
      AK_SRA:  y = W'($signed(a) >>> sh);
      default: begin
        y   = sum[W-1:0];
        c_o = sum[W];
        v_o = (x_op[W-1] == y_op[W-1]) && (sum[W-1] != x_op[W-1]);
      end
    endcase
    nzvc = {y[W-1], (y == '0), v_o, c_o};
  end

endmodule

// File: rtl/ex_agen.sv
module ex_agen #(
  parameter int W = 32
) (
  input  logic         rel,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] idx_base,
  input  logic [W-1:0] offs,
  output logic [W-1:0] ea
);

  logic [W-1:0] base;

  always_comb begin
    base = rel ? pc : idx_base;
    ea   = base + offs;
  end

endmodule

// File: rtl/ex_unit.sv
module ex_unit
  import ex_pkg::*;
#(
  parameter int W    = 32,
  parameter int IMMW = 13,
  parameter int REGW = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             issue,
  input  logic [OP_BITS+2*REGW+IMMW+1:0]   instr,
  input  logic [W-1:0]                     pc,
  input  logic [W-1:0]                     src_a,
  input  logic [W-1:0]                     src_b,
  output logic [W-1:0]                     alu_res,
  output logic                             alu_we,
  output logic [W-1:0]                     eff_addr,
  output logic                             mem_rd,
  output logic                             mem_wr,
  output logic [1:0]                       mem_size,
  output logic                             mem_sext,
  output logic [3:0]                       flags,
  output logic [REGW-1:0]                  dst_idx,
  output logic [REGW-1:0]                  src_a_idx
);

  localparam int IW    = OP_BITS + 2*REGW + IMMW + 2;
  localparam int OP_LO = IW - OP_BITS;
  localparam int SCC_B = OP_LO - 1;
  localparam int RD_LO = SCC_B - REGW;
  localparam int RA_LO = RD_LO - REGW;
  localparam int SEL_B = RA_LO - 1;
  localparam int EXTW  = W - IMMW;

  dec_t         dec;
  logic [W-1:0] opb;
  logic [3:0]   alu_nzvc;
  logic [3:0]   flags_q, flags_nx;
  logic         scc, flags_en;

  ex_decode u_dec (
    .op (instr[IW-1:OP_LO]),
    .d  (dec)
  );

  // second operand: register or sign-extended immediate
  always_comb begin
    if (instr[SEL_B])
      opb = {{EXTW{instr[IMMW-1]}}, instr[IMMW-1:0]};
    else
      opb = src_b;
  end

  ex_alu #(.W(W)) u_alu (
    .a     (src_a),
    .b     (opb),
    .kind  (dec.kind),
    .sub   (dec.sub),
    .rev   (dec.rev),
    .use_c (dec.use_c),
    .c_in  (flags_q[0]),
    .y     (alu_res),
    .nzvc  (alu_nzvc)
  );

  ex_agen #(.W(W)) u_agen (
    .rel      (dec.rel),
    .pc       (pc),
    .idx_base (src_a),
    .offs     (opb),
    .ea       (eff_addr)
  );

  assign scc       = instr[SCC_B];
  assign alu_we    = issue & dec.is_alu;
  assign mem_rd    = issue & dec.is_mem & ~dec.is_store;
  assign mem_wr    = issue & dec.is_mem & dec.is_store;
  assign mem_size  = dec.size;
  assign mem_sext  = dec.sext;
  assign dst_idx   = instr[RD_LO +: REGW];
  assign src_a_idx = instr[RA_LO +: REGW];
  assign flags     = flags_q;

  // condition register: next state
  always_comb begin
    flags_en = issue & scc & dec.is_alu;
    flags_nx = flags_en ? alu_nzvc : flags_q;
  end

  // condition register: state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_q <= '0;
    else if (flags_en)
      flags_q <= flags_nx;
  end

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(alu_we && scc) |=> $stable(flags));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && scc) |=> (flags[2] == ($past(alu_res) == '0)));

  // R6
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && scc) |=> (flags[3] == $past(alu_res[W-1])));

  // R6
  logic_no_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && scc && dec.kind != AK_ARITH) |=> (flags[1:0] == 2'b00));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({alu_we, mem_rd, mem_wr}));

  // R1
  imm_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr[SEL_B] |-> ((opb[W-1:IMMW-1] == '0) || (&opb[W-1:IMMW-1])));

endmodule

// File: tb/tb_ex_unit.sv
module tb_ex_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [31:0] instr, pc, src_a, src_b;
  logic [31:0] alu_res, eff_addr;
  logic        alu_we, mem_rd, mem_wr, mem_sext;
  logic [1:0]  mem_size;
  logic [3:0]  flags;
  logic [4:0]  dst_idx, src_a_idx;

  int total = 0;
  int bad   = 0;
  logic [3:0] exp_f;

  ex_unit dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .pc(pc),
    .src_a(src_a), .src_b(src_b), .alu_res(alu_res), .alu_we(alu_we),
    .eff_addr(eff_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_size(mem_size), .mem_sext(mem_sext), .flags(flags),
    .dst_idx(dst_idx), .src_a_idx(src_a_idx)
  );

  always #10 clk = ~clk;

  logic [31:0] vals [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
                            32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_001F,
                            32'h1234_5678, 32'hFFFF_FFE1};
  logic [12:0] imms [6] = '{13'h0000, 13'h0001, 13'h0FFF, 13'h1000,
                            13'h1FFF, 13'h0AAA};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [6:0] op);
    if (op <= 7'h02) return "R2";
    if (op <= 7'h06) return "R3";
    if (op <= 7'h09) return "R4";
    return "R5";
  endfunction

  task automatic model(input logic [6:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic cf,
                       output logic [31:0] r, output logic [3:0] f);
    longint s, u, x, y, ux, uy;
    logic   c, v;
    c = 1'b0; v = 1'b0;
    ux = longint'({32'h0, a}); uy = longint'({32'h0, b});
    x  = longint'($signed(a)); y = longint'($signed(b));
    case (op)
      7'h01, 7'h02: begin
        u = ux + uy + ((op == 7'h02) ? longint'(cf) : 0);
        s = x + y + ((op == 7'h02) ? longint'(cf) : 0);
        r = u[31:0]; c = u[32];
        v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      7'h03, 7'h04, 7'h05, 7'h06: begin
        longint bin;
        bin = (op == 7'h04 || op == 7'h06) ? longint'(!cf) : 0;
        if (op >= 7'h05) begin
          u = uy - ux - bin; s = y - x - bin;
        end else begin
          u = ux - uy - bin; s = x - y - bin;
        end
        r = u[31:0]; c = (u >= 0);
        v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      7'h07: r = a & b;
      7'h08: r = a | b;
      7'h09: r = a ^ b;
      7'h0A: r = a << b[4:0];
      7'h0B: r = a >> b[4:0];
      default: r = $signed(a) >>> b[4:0];
    endcase
    f = {r[31], r == 32'h0, v, c};
  endtask

  task automatic exec(input logic [6:0] op, input logic iss, input logic scc,
                      input logic sel, input logic [31:0] a, input logic [31:0] b,
                      input logic [12:0] imm, input logic [31:0] pcv);
    logic [31:0] opb, r, ea;
    logic [3:0]  f;
    logic        is_alu, is_mem, st;
    logic [1:0]  sz;
    logic [4:0]  rd, ra;
    rd = a[4:0] ^ 5'h13; ra = b[9:5];
    @(negedge clk);
    issue = iss; src_a = a; src_b = b; pc = pcv;
    instr = {op, scc, rd, ra, sel, sel ? imm : {b[12:5], b[4:0]}};
    #4;
    opb    = sel ? {{19{imm[12]}}, imm} : b;
    is_alu = (op >= 7'h01 && op <= 7'h0C);
    is_mem = (op >= 7'h10 && op <= 7'h1F);
    st     = is_mem && op[2:0] >= 3'd5;
    chk(dst_idx == rd && src_a_idx == ra, "R13", {22'h0, dst_idx, src_a_idx},
        {22'h0, rd, ra});
    chk(alu_we == (iss && is_alu), is_alu ? "R7" : "R12", 32'(alu_we), 32'(iss && is_alu));
    chk(mem_rd == (iss && is_mem && !st), is_mem ? "R10" : "R12", 32'(mem_rd),
        32'(iss && is_mem && !st));
    chk(mem_wr == (iss && st), is_mem ? "R10" : "R12", 32'(mem_wr), 32'(iss && st));
    if (is_alu) begin
      model(op, a, opb, exp_f[0], r, f);
      chk(alu_res === r, sel ? "R1" : req_of(op), alu_res, r);
    end else if (is_mem) begin
      ea = (op[3] ? pcv : a) + opb;
      chk(eff_addr === ea, op[3] ? "R9" : "R8", eff_addr, ea);
      case (op[2:0])
        3'd0, 3'd5: sz = 2'd2;
        3'd1, 3'd2, 3'd6: sz = 2'd1;
        default: sz = 2'd0;
      endcase
      chk(mem_size == sz, "R10", 32'(mem_size), 32'(sz));
      chk(mem_sext == (op[2:0] == 3'd1 || op[2:0] == 3'd3), "R10", 32'(mem_sext),
          32'(op[2:0] == 3'd1 || op[2:0] == 3'd3));
    end
    @(negedge clk);
    if (iss && scc && is_alu) begin
      exp_f = f;
      chk(flags === exp_f, "R6", 32'(flags), 32'(exp_f));
    end else begin
      chk(flags === exp_f, is_alu || is_mem ? "R7" : "R12", 32'(flags), 32'(exp_f));
    end
    issue = 1'b0;
  endtask

  task automatic set_carry(input logic cv);
    if (cv) exec(7'h01, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h1, 13'h0, 32'h0);
    else    exec(7'h01, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 13'h0, 32'h0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; issue = 1'b0; instr = '0; pc = '0; src_a = '0; src_b = '0;
    exp_f = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(flags == 4'h0, "R11", 32'(flags), 32'h0);
    chk(!alu_we && !mem_rd && !mem_wr, "R11", {29'h0, alu_we, mem_rd, mem_wr}, 32'h0);

    // R2 R3 R4 R5 R6: register operand sweep, both carry inputs
    for (int op = 1; op <= 12; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int cv = 0; cv < 2; cv++) begin
            set_carry(cv[0]);
            exec(7'(op), 1'b1, 1'b1, 1'b0, vals[i], vals[j], 13'h0, 32'h0);
          end

    // R1: immediate operand, register value must not matter
    for (int op = 1; op <= 12; op++)
      for (int k = 0; k < 6; k++)
        for (int i = 0; i < 8; i++)
          exec(7'(op), 1'b1, 1'b1, 1'b1, vals[i], 32'hDEAD_BEEF, imms[k], 32'h0);

    // R7: no update without set-condition bit or without issue
    exec(7'h03, 1'b1, 1'b1, 1'b0, 32'h0, 32'h1, 13'h0, 32'h0);
    for (int op = 1; op <= 12; op++)
      for (int i = 0; i < 8; i++) begin
        exec(7'(op), 1'b1, 1'b0, 1'b0, vals[i], vals[7-i], 13'h0, 32'h0);
        exec(7'(op), 1'b0, 1'b1, 1'b0, vals[i], vals[i], 13'h0, 32'h0);
      end

    // R8 R9 R10: address forms and access attributes
    for (int op = 16; op < 32; op++)
      for (int i = 0; i < 8; i++)
        for (int s = 0; s < 2; s++) begin
          exec(7'(op), 1'b1, 1'b1, s[0], vals[i], vals[(i+3)%8], imms[i%6],
               32'h0000_4000 + 32'(i*4));
          exec(7'(op), 1'b0, 1'b1, s[0], vals[i], vals[i], imms[0], 32'h100);
        end

    // R12: undefined opcodes, flags set to a non-zero pattern first
    exec(7'h03, 1'b1, 1'b1, 1'b0, 32'h8000_0000, 32'h1, 13'h0, 32'h0);
    for (int op = 0; op < 128; op++)
      if (op == 0 || (op >= 13 && op <= 15) || op >= 32)
        exec(7'(op), 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 13'h0, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule